// File: doc/BRIEF.md
# Trap Delegation Control Registers

This unit stores the two machine-level delegation registers of a hart. One register states which synchronous exceptions are handed down to supervisor mode. The other states which interrupts are handed down. A core's CSR pipeline drives an address, write data and a write strobe. The unit answers in the same cycle with read data, the legalized value that the write will store, and an illegal-access flag. Writes take effect at the next rising clock edge.

The exception-delegation state is always 64 bits wide, whatever the register width `XLEN` is.

- On a 64-bit build, one address covers the whole register.
- On a 32-bit build, the register is split over a low-word address and a high-word address. A write to either word is merged with the unchanged other word, then legalized as a full 64-bit value.
- Legalization always clears the bit that would delegate machine-mode environment calls, so that bit can never be set.

The interrupt-delegation register keeps only the bits named in a parameter mask.

Top module: `trap_deleg_csr`

## Requirements
- R1: After reset, both delegation registers hold zero. Reads of 0x302, 0x312 (32-bit build) and 0x303 return zero.
- R2: On a 32-bit build, a read of 0x302 returns bits 31..0 of the 64-bit exception-delegation state, and a read of 0x312 returns bits 63..32.
- R3: On a 32-bit build, a write to 0x302 leaves bits 63..32 unchanged, and a write to 0x312 leaves bits 31..0 unchanged. Every other bit, including bit 0 (misaligned fetch) and bits 12, 13 and 15 (page faults), takes the written value.
- R4: Bit 11 of the exception-delegation state (machine-mode environment-call delegation) is zero at all times, whatever value is written.
- R5: While a write to a valid address is presented, `csr_wres` shows the legalized value of the word being written. That is the value the word reads back after the clock edge.
- R6: On a 64-bit build, one write to 0x302 replaces all 64 bits after legalization, and a read of 0x302 returns all 64 bits.
- R7: On a 64-bit build, 0x312 is not a valid address: `csr_illegal` is 1, `csr_rdata` and `csr_wres` are zero, and a write there changes no state.
- R8: When supervisor mode is not supported (`HAS_SMODE`=0), all three addresses are illegal, read as zero and ignore writes.
- R9: Any other address raises `csr_illegal`, returns zero on `csr_rdata` and `csr_wres`, and a write there changes no state.
- R10: Register 0x303 keeps only the bits set in `IDELEG_MASK` (default: bits 1, 5 and 9). All other bits read as zero.
- R11: Reads are combinational from the stored state. A value written in one cycle becomes visible on `csr_rdata` only after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| csr_addr | input | 12 | CSR address of the access |
| csr_we | input | 1 | Write strobe, committed at the next rising edge |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Read data of the addressed register, combinational |
| csr_wres | output | XLEN | Legalized value of the word being written |
| csr_illegal | output | 1 | Address not valid for this configuration |

## Verification
The bench builds three instances side by side on one shared request bus:
- a 32-bit build with supervisor mode, which exposes the split high word and the merge of each half-write;
- a 64-bit build with supervisor mode, where 0x312 must be rejected while 0x302 writes the full register;
- a 32-bit build without supervisor mode, where every delegation address must be illegal.

Because the bus is shared, every write reaches all three configurations at once. A high-word write that is legal on the 32-bit build therefore also exercises the rejection path of the 64-bit build.

// File: rtl/trapdel_pkg.sv
package trapdel_pkg;

    localparam logic [11:0] CSR_EDELEG_LO = 12'h302;
    localparam logic [11:0] CSR_EDELEG_HI = 12'h312;
    localparam logic [11:0] CSR_IDELEG    = 12'h303;

    // exception-delegation bit that may never be set
    localparam int ECALL_M_BIT = 11;

    typedef struct packed {
        logic [63:0] edeleg;
        logic [63:0] ideleg;
    } deleg_state_t;

    typedef struct packed {
        logic lo;
        logic hi;
        logic ideleg;
        logic illegal;
    } csr_sel_t;

    function automatic logic [63:0] legalize_edeleg(input logic [63:0] raw);
        logic [63:0] res;
        res = raw;
        res[ECALL_M_BIT] = 1'b0;
        return res;
    endfunction

endpackage

// File: rtl/trapdel_decode.sv
module trapdel_decode
    import trapdel_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter bit HAS_SMODE = 1'b1
) (
    input  logic [11:0] addr,
    output csr_sel_t    sel
);
    // the high word exists only on 32-bit builds
    localparam bit HAS_HIGH = HAS_SMODE && (XLEN == 32);

    always_comb begin
        sel         = '0;
        sel.lo      = HAS_SMODE && (addr == CSR_EDELEG_LO);
        sel.hi      = HAS_HIGH  && (addr == CSR_EDELEG_HI);
        sel.ideleg  = HAS_SMODE && (addr == CSR_IDELEG);
        sel.illegal = !(sel.lo || sel.hi || sel.ideleg);
    end

endmodule

// File: rtl/trapdel_edeleg_merge.sv
module trapdel_edeleg_merge
    import trapdel_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [63:0]     old_val,
    input  logic [XLEN-1:0] wdata,
    input  logic            sel_hi,
    output logic [63:0]     merged,
    output logic [XLEN-1:0] half
);
    generate
        if (XLEN == 32) begin : g_split
            logic [63:0] raw;
            always_comb begin
                raw    = sel_hi ? {wdata, old_val[31:0]} : {old_val[63:32], wdata};
                merged = legalize_edeleg(raw);
                half   = sel_hi ? merged[63:32] : merged[31:0];
            end
        end else begin : g_full
            logic unused_full;
            assign unused_full = ^{old_val, sel_hi};
            always_comb begin
                merged = legalize_edeleg(64'(wdata));
                half   = merged[XLEN-1:0];
            end
        end
    endgenerate

endmodule

// File: rtl/trapdel_readmux.sv
module trapdel_readmux
    import trapdel_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  deleg_state_t    state,
    input  csr_sel_t        sel,
    output logic [XLEN-1:0] rdata
);
    logic unused_ideleg;
    assign unused_ideleg = ^{state.ideleg, sel.illegal};

    always_comb begin
        rdata = '0;
        if (sel.lo) begin
            rdata = state.edeleg[XLEN-1:0];
        end else if (sel.hi) begin
            rdata = state.edeleg[63 -: XLEN];
        end else if (sel.ideleg) begin
            rdata = state.ideleg[XLEN-1:0];
        end
    end

endmodule

// File: rtl/trap_deleg_csr.sv
module trap_deleg_csr
    import trapdel_pkg::*;
#(
    parameter int          XLEN        = 32,
    parameter bit          HAS_SMODE   = 1'b1,
    parameter logic [63:0] IDELEG_MASK = 64'h222
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [11:0]     csr_addr,
    input  logic            csr_we,
    input  logic [XLEN-1:0] csr_wdata,
    output logic [XLEN-1:0] csr_rdata,
    output logic [XLEN-1:0] csr_wres,
    output logic            csr_illegal
);
    localparam logic [63:0] IMASK = IDELEG_MASK & ({64{1'b1}} >> (64 - XLEN));

    deleg_state_t    state_d, state_q;
    csr_sel_t        sel;
    logic [63:0]     edeleg_merged;
    logic [XLEN-1:0] edeleg_half;

    trapdel_decode #(.XLEN(XLEN), .HAS_SMODE(HAS_SMODE)) u_decode (
        .addr (csr_addr),
        .sel  (sel)
    );

    trapdel_edeleg_merge #(.XLEN(XLEN)) u_merge (
        .old_val (state_q.edeleg),
        .wdata   (csr_wdata),
        .sel_hi  (sel.hi),
        .merged  (edeleg_merged),
        .half    (edeleg_half)
    );

    trapdel_readmux #(.XLEN(XLEN)) u_readmux (
        .state (state_q),
        .sel   (sel),
        .rdata (csr_rdata)
    );

    assign csr_illegal = sel.illegal;

    always_comb begin
        state_d  = state_q;
        csr_wres = '0;
        if (sel.lo || sel.hi) begin
            csr_wres = edeleg_half;
        end else if (sel.ideleg) begin
            csr_wres = csr_wdata & IMASK[XLEN-1:0];
        end
        if (csr_we) begin
            if (sel.lo || sel.hi) begin
                state_d.edeleg = edeleg_merged;
            end
            if (sel.ideleg) begin
                state_d.ideleg = 64'(csr_wdata) & IMASK;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/trap_deleg_csr_chk.sv
module trap_deleg_csr_chk
    import trapdel_pkg::*;
#(
    parameter int          XLEN        = 32,
    parameter logic [63:0] IDELEG_MASK = 64'h222
) (
    input logic            clk,
    input logic            rst_n,
    input logic [11:0]     csr_addr,
    input logic            csr_we,
    input logic            csr_illegal,
    input logic [XLEN-1:0] csr_rdata,
    input logic [XLEN-1:0] csr_wres,
    input logic [63:0]     edeleg_q,
    input logic [63:0]     ideleg_q
);
    logic wr_lo;
    assign wr_lo = csr_we && !csr_illegal && (csr_addr == CSR_EDELEG_LO);

    // R1
    reset_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (edeleg_q == 64'h0 && ideleg_q == 64'h0));

    // R4
    ecall_bit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !edeleg_q[ECALL_M_BIT]);

    // R9
    illegal_zero_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        csr_illegal |-> (csr_rdata == '0 && csr_wres == '0));

    // R9
    illegal_write_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we && csr_illegal) |=> (edeleg_q == $past(edeleg_q) && ideleg_q == $past(ideleg_q)));

    // R5
    wres_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> (edeleg_q[XLEN-1:0] == $past(csr_wres)));

    // R10
    ideleg_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ideleg_q & ~IDELEG_MASK) == 64'h0);

    generate
        if (XLEN == 32) begin : g_half_chk
            logic wr_hi;
            assign wr_hi = csr_we && !csr_illegal && (csr_addr == CSR_EDELEG_HI);

            // R3
            lo_keeps_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
                wr_lo |=> (edeleg_q[63:32] == $past(edeleg_q[63:32])));

            // R3
            hi_keeps_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
                wr_hi |=> (edeleg_q[31:0] == $past(edeleg_q[31:0])));
        end
    endgenerate

endmodule

bind trap_deleg_csr trap_deleg_csr_chk #(.XLEN(XLEN), .IDELEG_MASK(IDELEG_MASK)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .csr_addr    (csr_addr),
    .csr_we      (csr_we),
    .csr_illegal (csr_illegal),
    .csr_rdata   (csr_rdata),
    .csr_wres    (csr_wres),
    .edeleg_q    (state_q.edeleg),
    .ideleg_q    (state_q.ideleg)
);

// File: tb/test_trap_deleg_csr.sv
`timescale 1ns/1ps
module test_trap_deleg_csr;

    localparam logic [63:0] MASK = 64'h222;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] addr = '0;
    logic        we = 1'b0;
    logic [63:0] wd = '0;

    logic [31:0] rd0, wr0;
    logic        il0;
    logic [63:0] rd1, wr1;
    logic        il1;
    logic [31:0] rd2, wr2;
    logic        il2;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // bench models of the exception and interrupt delegation state, per instance
    logic [63:0] me [3];
    logic [63:0] mi [3];

    always #2.5 clk = ~clk;

    trap_deleg_csr #(.XLEN(32), .HAS_SMODE(1'b1)) i_trap_deleg_csr (
        .clk(clk), .rst_n(rst_n), .csr_addr(addr), .csr_we(we), .csr_wdata(wd[31:0]),
        .csr_rdata(rd0), .csr_wres(wr0), .csr_illegal(il0));

    trap_deleg_csr #(.XLEN(64), .HAS_SMODE(1'b1)) i_trap_deleg_csr_rv64 (
        .clk(clk), .rst_n(rst_n), .csr_addr(addr), .csr_we(we), .csr_wdata(wd),
        .csr_rdata(rd1), .csr_wres(wr1), .csr_illegal(il1));

    trap_deleg_csr #(.XLEN(32), .HAS_SMODE(1'b0)) i_trap_deleg_csr_nos (
        .clk(clk), .rst_n(rst_n), .csr_addr(addr), .csr_we(we), .csr_wdata(wd[31:0]),
        .csr_rdata(rd2), .csr_wres(wr2), .csr_illegal(il2));

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic sample(int k, output logic [63:0] rd, output logic [63:0] wres, output logic ill);
        case (k)
            0: begin rd = {32'h0, rd0}; wres = {32'h0, wr0}; ill = il0; end
            1: begin rd = rd1; wres = wr1; ill = il1; end
            default: begin rd = {32'h0, rd2}; wres = {32'h0, wr2}; ill = il2; end
        endcase
    endtask

    // {illegal, read data} expected from the requirements
    function automatic logic [64:0] exp_rd(int k, logic [11:0] a);
        if (k == 2) return {1'b1, 64'h0};
        if (a == 12'h302) return {1'b0, (k == 0) ? {32'h0, me[k][31:0]} : me[k]};
        if (a == 12'h312 && k == 0) return {1'b0, 32'h0, me[k][63:32]};
        if (a == 12'h303) return {1'b0, mi[k]};
        return {1'b1, 64'h0};
    endfunction

    task automatic model_wr(int k, logic [11:0] a, logic [63:0] d, output logic [63:0] wres);
        logic [63:0] n;
        wres = 64'h0;
        if (k == 0) begin
            if (a == 12'h302) begin
                n = {me[0][63:32], d[31:0]}; n[11] = 1'b0; me[0] = n; wres = {32'h0, n[31:0]};
            end else if (a == 12'h312) begin
                n = {d[31:0], me[0][31:0]}; n[11] = 1'b0; me[0] = n; wres = {32'h0, n[63:32]};
            end else if (a == 12'h303) begin
                mi[0] = {32'h0, d[31:0]} & MASK; wres = mi[0];
            end
        end else if (k == 1) begin
            if (a == 12'h302) begin
                n = d; n[11] = 1'b0; me[1] = n; wres = n;
            end else if (a == 12'h303) begin
                mi[1] = d & MASK; wres = mi[1];
            end
        end
    endtask

    task automatic wr(string tag, logic [11:0] a, logic [63:0] d);
        logic [64:0] e;
        logic [63:0] rd, wres, ew;
        logic ill;
        @(negedge clk);
        addr = a; wd = d; we = 1'b1;
        #1;
        for (int k = 0; k < 3; k++) begin
            e = exp_rd(k, a);
            sample(k, rd, wres, ill);
            chk("R11", rd, e[63:0]);           // old value still visible before the edge
            model_wr(k, a, d, ew);
            chk((k == 2) ? "R8" : tag, wres, ew);
            chk((k == 2) ? "R8" : tag, {63'h0, ill}, {63'h0, e[64]});
        end
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd_all(string tag);
        logic [11:0] al [3] = '{12'h302, 12'h312, 12'h303};
        logic [64:0] e;
        logic [63:0] rd, wres;
        logic ill;
        for (int j = 0; j < 3; j++) begin
            @(negedge clk);
            addr = al[j]; we = 1'b0;
            #1;
            for (int k = 0; k < 3; k++) begin
                e = exp_rd(k, al[j]);
                sample(k, rd, wres, ill);
                chk((k == 2) ? "R8" : tag, rd, e[63:0]);
                chk((k == 2) ? "R8" : tag, {63'h0, ill}, {63'h0, e[64]});
            end
        end
    endtask

    task automatic t_reset();
        rd_all("R1");
    endtask

    task automatic t_halves();
        wr("R5", 12'h302, 64'h0000_0000_1234_F00D);
        wr("R5", 12'h312, 64'h0000_0000_CAFE_0123);
        rd_all("R3");
        wr("R3", 12'h302, 64'h0000_0000_0000_B001);   // bits 0, 12, 13, 15
        rd_all("R2");
    endtask

    task automatic t_ecall();
        wr("R4", 12'h302, {64{1'b1}});
        wr("R4", 12'h312, {64{1'b1}});
        rd_all("R4");
        @(negedge clk);
        addr = 12'h302;
        #1;
        chk("R4", {63'h0, rd0[11]}, 64'h0);
        chk("R4", {63'h0, rd1[11]}, 64'h0);
    endtask

    task automatic t_rv64();
        wr("R6", 12'h302, 64'hDEAD_BEEF_0BAD_F00D);
        rd_all("R6");
        wr("R7", 12'h312, 64'h1111_2222_3333_4444);
        rd_all("R7");
    endtask

    task automatic t_other();
        wr("R9", 12'h300, {64{1'b1}});
        wr("R9", 12'h304, 64'h5555_5555_5555_5555);
        wr("R9", 12'h313, {64{1'b1}});
        wr("R9", 12'h702, 64'h0);
        rd_all("R9");
    endtask

    task automatic t_ideleg();
        wr("R10", 12'h303, {64{1'b1}});
        rd_all("R10");
        wr("R10", 12'h303, 64'h0000_0000_0000_0021);
        rd_all("R10");
    endtask

    initial begin
        for (int k = 0; k < 3; k++) begin
            me[k] = 64'h0;
            mi[k] = 64'h0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_halves();
        t_ecall();
        t_rv64();
        t_other();
        t_ideleg();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule